// File: doc/BRIEF.md
# Rotating Module Pulse Distributor

This block sits behind a single-carrier arm modulator of a series-stacked converter arm. The modulator supplies the number of modules that must be fully inserted for the coming carrier period, one PWM bit produced by comparing the fractional duty with the carrier, and a one-cycle strobe at each carrier-period boundary. The distributor turns these into one gate signal per module. It needs no per-module comparator.

Roles are assigned by a rotation pointer. Take the module at the pointer as offset 0 and walk upwards modulo N. The first `cnt` modules by offset are held on. The next module carries the PWM bit. All the others are held off. The pointer steps by one at every strobe, so the switching role and the inserted positions move around the arm. Each module therefore passes through every role within N carrier periods, which spreads switching losses and charge flow evenly.

A mode input selects upper-arm polarity or the complementary lower-arm polarity. An enable input forces every gate low, which is the standby state.

Top module: `rot_pulse_dist`

## Requirements
- R1: After reset, no module holds the on or PWM role. With `enable_i` high, `gate_o` is all zeros in upper mode (`lower_arm_i`=0) and all ones in lower mode (`lower_arm_i`=1).
- R2: While `enable_i` is low, `gate_o` is all zeros, whatever the other inputs are.
- R3: Roles are captured at the rising clock edge where `strobe_i` is high. They then hold until the next strobe, so changing `on_cnt_i` between strobes has no effect on `gate_o`.
- R4: At a strobe, module k gets offset o = (k − p) mod N, where p is the pointer value. Module k is on if o < c, takes the PWM role if o = c, and is off if o > c. Here c is the captured count.
- R5: The pointer is 0 after reset, so the first period after reset is based at module 0. Every strobe advances the pointer by one, modulo N.
- R6: In upper mode the gate of the PWM-role module equals `pwm_i` in the same cycle. On-role gates are 1 and off-role gates are 0.
- R7: In lower mode every gate is the complement of the value it would have in upper mode, including the PWM-role gate, which becomes the inverse of `pwm_i`.
- R8: A value of `on_cnt_i` above N−1 is captured as N−1. Exactly one module then takes the PWM role, and no module is off.
- R9: With a constant count, each module takes the PWM role exactly once in any N consecutive periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Low forces all gates off (standby) |
| lower_arm_i | input | 1 | 1 selects complementary lower-arm polarity |
| strobe_i | input | 1 | Carrier-period boundary, one cycle wide |
| on_cnt_i | input | $clog2(N_MOD) | Number of fully-on modules for the next period |
| pwm_i | input | 1 | PWM bit for the switching module |
| gate_o | output | N_MOD | Module gate signals, bit k for module k |

## Verification
The following are checked on every cycle:
- the standby forcing of the gates;
- that roles do not change between strobes;
- that each strobe yields exactly one PWM role and the saturated number of on roles;
- the single step of the pointer;
- that the PWM-role gate tracks `pwm_i`;
- the gate count implied by the lower-arm complement.

Some behaviours can only be shown by the bench's scenarios:
- the exact module index of each role for a given pointer and count;
- the reset base at module 0;
- the even sharing of the PWM role across a full rotation;
- that a changed count has no effect until the next strobe.

// File: rtl/rot_pulse_dist_pkg.sv
package rot_pulse_dist_pkg;
  typedef enum logic [1:0] {
    ROLE_OFF = 2'd0,
    ROLE_ON  = 2'd1,
    ROLE_PWM = 2'd2
  } role_e;
endpackage

// File: rtl/rpd_pointer.sv
module rpd_pointer #(
  parameter int N_MOD = 6,
  localparam int PW = $clog2(N_MOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(N_MOD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_o <= '0;
    else if (strobe_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/rpd_role_map.sv
module rpd_role_map
  import rot_pulse_dist_pkg::*;
#(
  parameter int N_MOD = 6,
  localparam int PW = $clog2(N_MOD),
  localparam int PW1 = PW + 1
) (
  input  logic [PW-1:0] ptr_i,
  input  logic [PW-1:0] cnt_i,
  output role_e         role_o [N_MOD]
);
  localparam logic [PW1-1:0] NN = PW1'(N_MOD);
  logic [PW-1:0] cnt_sat;

  always_comb begin
    if (int'(cnt_i) > N_MOD - 1) cnt_sat = PW'(N_MOD - 1);
    else                          cnt_sat = cnt_i;
  end

  for (genvar k = 0; k < N_MOD; k++) begin : g_mod
    logic [PW1-1:0] diff;
    logic [PW1-1:0] offs;
    always_comb begin
      diff = PW1'(k) + NN - {1'b0, ptr_i};
      offs = (diff >= NN) ? diff - NN : diff;
      if (offs < {1'b0, cnt_sat})       role_o[k] = ROLE_ON;
      else if (offs == {1'b0, cnt_sat}) role_o[k] = ROLE_PWM;
      else                              role_o[k] = ROLE_OFF;
    end
  end
endmodule

// File: rtl/rpd_gate_drv.sv
module rpd_gate_drv
  import rot_pulse_dist_pkg::*;
#(
  parameter int N_MOD = 6
) (
  input  role_e             role_i [N_MOD],
  input  logic              pwm_i,
  input  logic              lower_i,
  input  logic              en_i,
  output logic [N_MOD-1:0]  gate_o
);
  for (genvar k = 0; k < N_MOD; k++) begin : g_gate
    logic raw;
    always_comb begin
      unique case (role_i[k])
        ROLE_ON:  raw = 1'b1;
        ROLE_PWM: raw = pwm_i;
        default:  raw = 1'b0;
      endcase
      gate_o[k] = en_i & (raw ^ lower_i);
    end
  end
endmodule

// File: rtl/rot_pulse_dist.sv
module rot_pulse_dist
  import rot_pulse_dist_pkg::*;
#(
  parameter int N_MOD = 6,
  localparam int PW = $clog2(N_MOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             lower_arm_i,
  input  logic             strobe_i,
  input  logic [PW-1:0]    on_cnt_i,
  input  logic             pwm_i,
  output logic [N_MOD-1:0] gate_o
);
  logic [PW-1:0] ptr_q;
  role_e         role_d [N_MOD];
  role_e         role_q [N_MOD];

  rpd_pointer #(.N_MOD(N_MOD)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .ptr_o    (ptr_q)
  );

  rpd_role_map #(.N_MOD(N_MOD)) u_map (
    .ptr_i  (ptr_q),
    .cnt_i  (on_cnt_i),
    .role_o (role_d)
  );

  // roles only move at the period boundary
  for (genvar k = 0; k < N_MOD; k++) begin : g_role
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       role_q[k] <= ROLE_OFF;
      else if (strobe_i) role_q[k] <= role_d[k];
    end
  end

  rpd_gate_drv #(.N_MOD(N_MOD)) u_drv (
    .role_i  (role_q),
    .pwm_i   (pwm_i),
    .lower_i (lower_arm_i),
    .en_i    (enable_i),
    .gate_o  (gate_o)
  );
endmodule

// File: rtl/rot_pulse_dist_chk.sv
module rot_pulse_dist_chk
  import rot_pulse_dist_pkg::*;
#(
  parameter int N_MOD = 6,
  localparam int PW = $clog2(N_MOD)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             lower_arm_i,
  input logic             strobe_i,
  input logic [PW-1:0]    on_cnt_i,
  input logic             pwm_i,
  input logic [N_MOD-1:0] gate_o,
  input logic [PW-1:0]    ptr_q,
  input role_e            role_q [N_MOD]
);
  logic [N_MOD-1:0] on_mask, pwm_mask;
  int exp_on;

  always_comb begin
    for (int k = 0; k < N_MOD; k++) begin
      on_mask[k]  = (role_q[k] == ROLE_ON);
      pwm_mask[k] = (role_q[k] == ROLE_PWM);
    end
    exp_on = N_MOD - $countones(on_mask) - ((pwm_mask != '0 && pwm_i) ? 1 : 0);
  end

  p_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> gate_o == '0);

  p_roles_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(on_mask) && $stable(pwm_mask)));

  p_single_pwm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> $countones(pwm_mask) == 1);

  p_on_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> $countones(on_mask) ==
      ((int'($past(on_cnt_i)) > N_MOD - 1) ? N_MOD - 1 : int'($past(on_cnt_i))));

  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> int'(ptr_q) == ((int'($past(ptr_q)) + 1) % N_MOD));

  p_pwm_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !lower_arm_i) |-> (((gate_o & pwm_mask) != '0) == (pwm_i && pwm_mask != '0)));

  p_lower_inv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && lower_arm_i) |-> $countones(gate_o) == exp_on);
endmodule

bind rot_pulse_dist rot_pulse_dist_chk #(.N_MOD(N_MOD)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .lower_arm_i (lower_arm_i),
  .strobe_i    (strobe_i),
  .on_cnt_i    (on_cnt_i),
  .pwm_i       (pwm_i),
  .gate_o      (gate_o),
  .ptr_q       (ptr_q),
  .role_q      (role_q)
);

// File: tb/rot_pulse_dist_tb.sv
module rot_pulse_dist_tb;
  localparam int N = 6;
  localparam int PW = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, lower_arm_i = 1'b0, strobe_i = 1'b0, pwm_i = 1'b0;
  logic [PW-1:0] on_cnt_i = '0;
  logic [N-1:0] gate_o;

  int checks = 0, errors = 0;
  int m_ptr = 0, m_base = 0, m_cnt = 0;
  bit m_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_pulse_dist #(.N_MOD(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .lower_arm_i(lower_arm_i),
    .strobe_i(strobe_i), .on_cnt_i(on_cnt_i), .pwm_i(pwm_i), .gate_o(gate_o)
  );

  function automatic logic [N-1:0] exp_gates(input bit pwm, input bit low, input bit en);
    logic [N-1:0] g;
    for (int k = 0; k < N; k++) begin
      int o;
      bit raw;
      o = (k - m_base + N) % N;
      if (!m_valid)        raw = 0;
      else if (o < m_cnt)  raw = 1;
      else if (o == m_cnt) raw = pwm;
      else                 raw = 0;
      g[k] = en & (raw ^ low);
    end
    return g;
  endfunction

  task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gate_o actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_now(input string req);
    #1;
    check_vec(req, gate_o, exp_gates(pwm_i, lower_arm_i, enable_i));
  endtask

  task automatic do_strobe(input int cnt);
    @(negedge clk);
    on_cnt_i = PW'(cnt);
    strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    m_base = m_ptr;
    m_cnt = (cnt > N - 1) ? N - 1 : cnt;
    m_valid = 1;
    m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic t_reset();
    enable_i = 1; lower_arm_i = 0; pwm_i = 1;
    check_now("R1 upper after reset");
    check_vec("R1 upper zeros", gate_o, '0);
    lower_arm_i = 1;
    check_now("R1 lower after reset");
    check_vec("R1 lower ones", gate_o, '1);
    lower_arm_i = 0;
  endtask

  task automatic t_rotation();
    for (int i = 0; i < 2 * N; i++) begin
      do_strobe(2);
      pwm_i = 0; check_now("R4 R5 rotation pwm0");
      pwm_i = 1; check_now("R6 rotation pwm1");
    end
  endtask

  task automatic t_first_base();
    // first period after reset is based at module 0, cnt=1: module0 on, module1 pwm
    pwm_i = 0; lower_arm_i = 0; enable_i = 1;
    do_strobe(1);
    #1 check_vec("R5 base at module 0", gate_o, N'(1));
  endtask

  task automatic t_even_share();
    int hits [N];
    for (int k = 0; k < N; k++) hits[k] = 0;
    lower_arm_i = 0;
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] g0, g1;
      do_strobe(3);
      pwm_i = 0; #1 g0 = gate_o;
      pwm_i = 1; #1 g1 = gate_o;
      for (int k = 0; k < N; k++) if (g0[k] != g1[k]) hits[k]++;
    end
    for (int k = 0; k < N; k++) begin
      checks++;
      if (hits[k] != 1) begin
        errors++;
        $display("FAIL R9: module %0d pwm count actual %0d expected 1", k, hits[k]);
      end
    end
  endtask

  task automatic t_hold();
    do_strobe(1);
    pwm_i = 1;
    check_now("R3 before change");
    @(negedge clk); on_cnt_i = PW'(4);
    @(negedge clk); @(negedge clk);
    check_now("R3 count change ignored");
  endtask

  task automatic t_saturate();
    do_strobe(7);
    pwm_i = 0; check_now("R8 saturate pwm0");
    pwm_i = 1; check_now("R8 saturate pwm1");
    #1 check_vec("R8 all on", gate_o, '1);
  endtask

  task automatic t_zero_count();
    do_strobe(0);
    pwm_i = 1; check_now("R4 zero count pwm1");
    pwm_i = 0; check_now("R4 zero count pwm0");
  endtask

  task automatic t_lower();
    lower_arm_i = 1;
    for (int i = 0; i < 3; i++) begin
      do_strobe(2 + i);
      pwm_i = 0; check_now("R7 lower pwm0");
      pwm_i = 1; check_now("R7 lower pwm1");
    end
    lower_arm_i = 0;
  endtask

  task automatic t_standby();
    enable_i = 0;
    do_strobe(3);
    pwm_i = 1; lower_arm_i = 1;
    check_now("R2 standby lower");
    #1 check_vec("R2 standby zeros", gate_o, '0);
    lower_arm_i = 0;
    check_now("R2 standby upper");
    enable_i = 1;
    check_now("R2 re-enable");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_first_base();
    t_rotation();
    t_even_share();
    t_hold();
    t_saturate();
    t_zero_count();
    t_lower();
    t_standby();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule